// File: doc/BRIEF.md
# Software-initiated loop buffer controller

This block sits between the instruction fetch of a core and a one-cycle L1 instruction memory. It controls a small tagless buffer that holds one loop body. When the core decodes a loop-on instruction, it passes the instruction's own address and an offset. The loop body then starts at the next address and ends that many words later. While the block is in loop mode, every fetch inside that range is looked up by its distance from the loop start, not by a tag.

The first fetch of each word in the range is read from L1. The word is handed to the datapath and kept in the buffer in the same access. Any later fetch of a kept word is served from the buffer, and L1 sees no request. A fetch outside the range drops the block back to plain L1 fetching. Both paths answer one cycle after the request, so the buffer never costs a cycle.

Top module: `loop_buf_ctrl`

## Requirements
- R1: A loop-on pulse with address P and offset K, where K < DEPTH (128 by default), sets the loop range to P+1 through P+1+K inclusive. This takes effect for fetches from the next cycle onward, including the boundary case K = DEPTH-1, which uses all 128 entries.
- R2: In loop mode, a fetch of an in-range address whose entry has not been filled raises `l1_req` with `l1_addr` equal to the fetch address. The word returned is delivered to the datapath and stored in the buffer.
- R3: In loop mode, a fetch of an in-range address whose entry is filled keeps `l1_req` low. The word delivered is the one stored during the fill.
- R4: A fetch of an address outside the range while in loop mode ends the mode. That fetch and every later one go to L1. A re-fetch of a formerly buffered address also goes to L1.
- R5: Every fetch request returns its instruction on `instr_data` exactly one cycle later, with `instr_valid` high. `instr_valid` is low in any cycle that does not follow a fetch.
- R6: Fetches that jump around inside the range, in non-sequential order, keep the block in loop mode. Already filled entries are served without L1 requests.
- R7: An entry is filled whenever it is first fetched, also in a later pass through the loop, after earlier passes skipped it.
- R8: A loop-on pulse with offset >= DEPTH is not accepted. The block is, or stays, in normal mode, and every fetch raises `l1_req`.
- R9: Any loop-on pulse discards all filled entries. After a new loop-on, even one naming the same range, each address is read from L1 again on its first fetch.
- R10: During and right after reset the block is in normal mode, with `instr_valid` low and `l1_req` low when no fetch is requested.
- R11: Whenever `l1_req` is high, `l1_addr` equals `fetch_pc`. A request is raised only in a cycle with a fetch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core requests the instruction at `fetch_pc` |
| fetch_pc | input | AW | Fetch address in words |
| lbon_valid | input | 1 | Loop-on instruction decoded this cycle |
| lbon_pc | input | AW | Address of the loop-on instruction |
| lbon_offset | input | OW | Distance from loop start to loop end |
| l1_req | output | 1 | Read request to L1 |
| l1_addr | output | AW | L1 read address |
| l1_data | input | IW | L1 read data, one cycle after `l1_req` |
| instr_valid | output | 1 | Instruction for the datapath is present |
| instr_data | output | IW | Instruction for the datapath |

## Verification
A wrong valid bit or a stale range shows up at the ports in the same cycle as the next fetch of the affected address. A request appears on `l1_req` that should not be there, or one is missing. A buffer entry written with the wrong data, or read from the wrong index, corrupts `instr_data` one cycle after the fetch. This is visible because the bench drives garbage on `l1_data` in cycles without a read. Missed invalidation on exit or on a new loop-on shows at the first re-fetch of an old address. The bench therefore revisits addresses across mode changes.

// File: rtl/loop_buf_ctrl.sv
module loop_buf_ctrl #(
  parameter int AW    = 16,
  parameter int IW    = 32,
  parameter int OW    = 8,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_pc,
  input  logic          lbon_valid,
  input  logic [AW-1:0] lbon_pc,
  input  logic [OW-1:0] lbon_offset,
  output logic          l1_req,
  output logic [AW-1:0] l1_addr,
  input  logic [IW-1:0] l1_data,
  output logic          instr_valid,
  output logic [IW-1:0] instr_data
);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic            active;
  logic [AW-1:0]   lo_q, hi_q;
  logic [DEPTH-1:0] vld;
  logic [IW-1:0]   mem [DEPTH];
  logic            rsp_v, rsp_buf, fill_q;
  logic [IDXW-1:0] fill_idx;
  logic [IW-1:0]   buf_q;

  wire            in_rng = active && (fetch_pc >= lo_q) && (fetch_pc <= hi_q);
  wire [IDXW-1:0] idx    = IDXW'(fetch_pc - lo_q);
  wire            hit    = fetch_req && in_rng && vld[idx];
  wire            leave  = fetch_req && active && !in_rng;
  wire            wipe   = lbon_valid || leave;
  wire            lb_ok  = 32'(lbon_offset) < DEPTH;
  wire [AW-1:0]   nlo    = lbon_pc + AW'(1);

  assign l1_req      = fetch_req && !hit;
  assign l1_addr     = fetch_pc;
  assign instr_valid = rsp_v;
  assign instr_data  = rsp_buf ? buf_q : l1_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      vld      <= '0;
      rsp_v    <= 1'b0;
      rsp_buf  <= 1'b0;
      fill_q   <= 1'b0;
      fill_idx <= '0;
    end else begin
      rsp_v    <= fetch_req;
      rsp_buf  <= hit;
      fill_q   <= fetch_req && in_rng && !vld[idx] && !lbon_valid;
      fill_idx <= idx;
      if (wipe) vld <= '0;
      else if (fill_q) vld[fill_idx] <= 1'b1;
      if (lbon_valid) begin
        active <= lb_ok;
        lo_q   <= nlo;
        hi_q   <= nlo + AW'(lbon_offset);
      end else if (leave) begin
        active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_q) mem[fill_idx] <= l1_data;
    if (hit) buf_q <= mem[idx];
  end

  // R5
  resp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> instr_valid);
  // R5
  no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> !instr_valid);
  // R8
  oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lbon_valid && !lb_ok) |=> (!active && vld == '0));
  // R4
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && !lbon_valid) |=> (!active && vld == '0));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lbon_valid |=> (vld == '0));
  // R3
  hit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !l1_req) |-> active);
  // R11
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req |-> fetch_req);
endmodule

// File: tb/tb_loop_buf_ctrl.sv
module tb_loop_buf_ctrl;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        lbon_valid = 1'b0;
  logic [15:0] lbon_pc = '0;
  logic [7:0]  lbon_offset = '0;
  logic        l1_req;
  logic [15:0] l1_addr;
  logic [31:0] l1_data = 32'hDEAD_BEEF;
  logic        instr_valid;
  logic [31:0] instr_data;

  loop_buf_ctrl #(.AW(16), .IW(32), .OW(8), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .lbon_valid(lbon_valid), .lbon_pc(lbon_pc), .lbon_offset(lbon_offset),
    .l1_req(l1_req), .l1_addr(l1_addr), .l1_data(l1_data),
    .instr_valid(instr_valid), .instr_data(instr_data));

  always #4 clk = ~clk;

  function automatic logic [31:0] memf(input int a);
    logic [15:0] w;
    w = 16'(a);
    return {w ^ 16'h5A5A, ~w};
  endfunction

  always @(posedge clk)
    l1_data <= l1_req ? memf(int'(l1_addr)) : 32'hDEAD_BEEF;

  int total = 0, bad = 0;
  string cur_tag = "R10";

  bit m_act = 0;
  int m_lo = 0, m_hi = 0;
  bit m_vld [int];
  bit pend = 0;
  int pend_a = 0;
  bit e_v = 0;
  int e_pc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic step(input bit req, input int pc, input bit lb = 0, input int lbpc = 0, input int off = 0);
    bit inr, hit, ereq, lv;
    @(negedge clk);
    fetch_req = req; fetch_pc = 16'(pc);
    lbon_valid = lb; lbon_pc = 16'(lbpc); lbon_offset = 8'(off);
    #1;
    chk(instr_valid == e_v, "R5", 32'(instr_valid), 32'(e_v));
    if (e_v) chk(instr_data == memf(e_pc), "R5", instr_data, memf(e_pc));
    inr  = m_act && pc >= m_lo && pc <= m_hi;
    hit  = req && inr && m_vld.exists(pc);
    ereq = req && !hit;
    chk(l1_req == ereq, cur_tag, 32'(l1_req), 32'(ereq));
    if (ereq) chk(l1_addr == 16'(pc), "R11", 32'(l1_addr), 32'(pc));
    lv = req && m_act && !inr;
    if (lb || lv) m_vld.delete();
    else if (pend) m_vld[pend_a] = 1;
    pend = req && inr && !m_vld.exists(pc) && !lb;
    pend_a = pc;
    if (lb) begin
      m_act = off < DEPTH; m_lo = lbpc + 1; m_hi = lbpc + 1 + off;
    end else if (lv) m_act = 0;
    e_v = req; e_pc = pc;
  endtask

  task automatic run(input int a, input int b);
    for (int i = a; i <= b; i++) step(1, i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk); #1;
      chk(instr_valid == 1'b0, "R10", 32'(instr_valid), 0);
      chk(l1_req == 1'b0, "R10", 32'(l1_req), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    cur_tag = "R10"; step(0, 0); step(0, 0);
    cur_tag = "R5"; run(16'h10, 16'h14); step(0, 0); step(1, 16'h15); step(0, 0);
    cur_tag = "R1"; step(1, 16'h1F); step(0, 0, 1, 16'h20, 5);
    cur_tag = "R2"; run(16'h21, 16'h26);
    cur_tag = "R3"; run(16'h21, 16'h26); run(16'h21, 16'h26);
    cur_tag = "R6"; step(1, 16'h21); step(1, 16'h24); step(1, 16'h22);
    step(1, 16'h26); step(1, 16'h23); step(1, 16'h23); step(0, 0); step(1, 16'h25);
    cur_tag = "R4"; step(1, 16'h27); run(16'h21, 16'h26); run(16'h21, 16'h23);
    cur_tag = "R7"; step(0, 0, 1, 16'h40, 9);
    run(16'h41, 16'h44); run(16'h48, 16'h4A);
    run(16'h41, 16'h4A); run(16'h41, 16'h4A);
    cur_tag = "R9"; step(1, 16'h42, 1, 16'h40, 9); run(16'h41, 16'h4A); run(16'h41, 16'h4A);
    step(0, 0, 1, 16'h60, 3); run(16'h61, 16'h64); run(16'h61, 16'h64);
    cur_tag = "R8"; step(0, 0, 1, 16'h80, 128); run(16'h81, 16'h88); run(16'h81, 16'h88);
    step(0, 0, 1, 16'h90, 2); run(16'h91, 16'h93); step(0, 0, 1, 16'h90, 200);
    run(16'h91, 16'h93);
    cur_tag = "R1"; step(0, 0, 1, 16'h100, 127); run(16'h101, 16'h180);
    cur_tag = "R3"; run(16'h101, 16'h180);
    cur_tag = "R4"; step(1, 16'h181); step(1, 16'h100); run(16'h101, 16'h104);
    cur_tag = "R5"; step(0, 0); step(0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule